// File: doc/BRIEF.md
# DMA Channel Address Generator

This block generates the byte address for one DMA channel, either source or target, on each transfer step. A load pulse captures the channel setup. That setup is a 24-bit descriptor address, a megabyte-select byte, a signed 8.8 fixed-point step and a revision flag. From then on the block keeps a running offset with eight fractional bits. The physical address is a megabyte base joined to the 20-bit integer part of that offset, so the channel always stays inside its own 1 MiB slice.

When the descriptor requests I/O, routing is decided separately for every access. An access goes to the I/O side only if address bits 15:12 equal 0xD. Every other access goes to memory. The block also gates the write enable: a byte that matches the configured transparency value is not written.

Two channels are built from two instances. A sequencer pulses the step strobe once per byte. It reads the address, the I/O select and the write enable one cycle later.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset is held and after it is released, addr_o, io_sel_o, wr_en_o, wdata_o and valid_o are all zero.
- R2: A load sets the offset to descriptor bits 19:0 with an all-zero fraction. The first access after the load therefore addresses base plus descriptor bits 19:0.
- R3: Each access advances the offset by the step latched at load, read as the signed 16-bit value {integer byte, fraction byte}. The address uses only the integer part of the offset, so a step of 0x0080 gives each byte address twice.
- R4: A zero step holds the offset, so every access repeats the same address.
- R5: The 20-bit integer offset wraps modulo 2^20 in both directions. Address bits 27:20 keep the base through the wrap.
- R6: With the revision flag clear at load, address bits 27:20 equal the megabyte-select byte.
- R7: With the revision flag set at load, address bits 27:20 equal (megabyte-select + descriptor bits 22:20) mod 256.
- R8: io_sel_o is 1 only when descriptor bit 23 was set at load and the presented address has bits 15:12 equal to 0xD. In every other case it is 0.
- R9: wr_en_o equals wr_req_i, except that it is forced to 0 when transp_en_i is 1 and wdata_i equals transp_val_i. wdata_o carries the byte that was presented.
- R10: All outputs follow a step strobe by exactly one cycle. valid_o pulses for one cycle per strobe. A load in the same cycle as a strobe cancels the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture the channel setup |
| desc_addr_i | input | 24 | Descriptor address: bit 23 is the I/O request, bits 22:20 are the megabyte add-on, bits 19:0 are the start offset |
| mbyte_i | input | 8 | Megabyte-select byte |
| rev_i | input | 1 | Revision flag: adds descriptor bits 22:20 to the megabyte |
| step_int_i | input | 8 | Step integer byte (signed as the upper half) |
| step_frac_i | input | 8 | Step fraction byte |
| step_i | input | 1 | Transfer step strobe |
| wr_req_i | input | 1 | This step is a write |
| wdata_i | input | 8 | Write data for this step |
| transp_en_i | input | 1 | Enable transparency gating |
| transp_val_i | input | 8 | Transparency byte |
| addr_o | output | 28 | Physical byte address |
| io_sel_o | output | 1 | Access goes to the I/O side |
| wr_en_o | output | 1 | Gated write enable |
| wdata_o | output | 8 | Registered write data |
| valid_o | output | 1 | Outputs describe an access |

## Verification
Every result (address, I/O select, gated write enable, data and valid) is due exactly one clock after the strobe edge. The offset update that the strobe causes is seen only at the next strobe. The bench drives the strobe on a falling edge and reads all outputs on the following falling edge. Only after that does it advance its arithmetic model of the offset, so the value it expects always belongs to the access just presented. For the same-cycle load and strobe, the bench checks at that same falling edge that no valid pulse appears.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int unsigned IO_LSB  = 12;
  localparam logic [3:0]  IO_PAGE = 4'hD;

  typedef struct packed {
    logic       io_en;
    logic [7:0] mb;
  } chan_cfg_t;

  function automatic logic in_io_page(input logic [15:0] a);
    return a[IO_LSB+3:IO_LSB] == IO_PAGE;
  endfunction
endpackage

// File: rtl/dag_base.sv
module dag_base #(
  parameter int unsigned MB_W = 8
) (
  input  logic [MB_W-1:0] mbyte_i,
  input  logic [2:0]      hi_i,
  input  logic            rev_i,
  output logic [MB_W-1:0] mb_o
);
  always_comb begin
    if (rev_i) mb_o = mbyte_i + {{(MB_W-3){1'b0}}, hi_i};
    else       mb_o = mbyte_i;
  end
endmodule

// File: rtl/dag_offset.sv
module dag_offset #(
  parameter int unsigned OFS_W  = 28,
  parameter int unsigned STEP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [OFS_W-1:0]  init_i,
  input  logic              adv_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [OFS_W-1:0]  ofs_o
);
  logic [OFS_W-1:0] step_ext;
  assign step_ext = {{(OFS_W-STEP_W){step_i[STEP_W-1]}}, step_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ofs_o <= '0;
    else if (load_i) ofs_o <= init_i;
    else if (adv_i)  ofs_o <= ofs_o + step_ext;
  end
endmodule

// File: rtl/dag_route.sv
module dag_route #(
  parameter int unsigned PA_W   = 28,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [PA_W-1:0]   phys_i,
  input  logic              io_en_i,
  input  logic              wr_req_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              transp_en_i,
  input  logic [DATA_W-1:0] transp_val_i,
  output logic [PA_W-1:0]   addr_o,
  output logic              io_sel_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              valid_o
);
  import dag_pkg::*;

  logic io_hit, transp_hit;
  assign io_hit     = io_en_i && in_io_page(phys_i[15:0]);
  assign transp_hit = transp_en_i && (wdata_i == transp_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= '0;
      io_sel_o <= 1'b0;
      wr_en_o  <= 1'b0;
      wdata_o  <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o  <= fire_i;
      io_sel_o <= fire_i && io_hit;
      wr_en_o  <= fire_i && wr_req_i && !transp_hit;
      if (fire_i) begin
        addr_o  <= phys_i;
        wdata_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int unsigned SLICE_W    = 20,
  parameter int unsigned FRAC_W     = 8,
  parameter int unsigned STEP_INT_W = 8,
  parameter int unsigned MB_W       = 8,
  parameter int unsigned DATA_W     = 8,
  localparam int unsigned DESC_W    = SLICE_W + 4,
  localparam int unsigned OFS_W     = SLICE_W + FRAC_W,
  localparam int unsigned STEP_W    = STEP_INT_W + FRAC_W,
  localparam int unsigned PA_W      = SLICE_W + MB_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [DESC_W-1:0]     desc_addr_i,
  input  logic [MB_W-1:0]       mbyte_i,
  input  logic                  rev_i,
  input  logic [STEP_INT_W-1:0] step_int_i,
  input  logic [FRAC_W-1:0]     step_frac_i,
  input  logic                  step_i,
  input  logic                  wr_req_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic                  transp_en_i,
  input  logic [DATA_W-1:0]     transp_val_i,
  output logic [PA_W-1:0]       addr_o,
  output logic                  io_sel_o,
  output logic                  wr_en_o,
  output logic [DATA_W-1:0]     wdata_o,
  output logic                  valid_o
);
  logic [MB_W-1:0]   mb_sel, mb_q;
  logic              io_en_q;
  logic [STEP_W-1:0] step_q;
  logic [OFS_W-1:0]  ofs, ofs_init;
  logic [PA_W-1:0]   phys;
  logic              fire;

  assign fire     = step_i && !load_i;  // load wins
  assign ofs_init = {desc_addr_i[SLICE_W-1:0], {FRAC_W{1'b0}}};

  dag_base #(.MB_W(MB_W)) u_base (
    .mbyte_i (mbyte_i),
    .hi_i    (desc_addr_i[SLICE_W+2:SLICE_W]),
    .rev_i   (rev_i),
    .mb_o    (mb_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mb_q    <= '0;
      io_en_q <= 1'b0;
      step_q  <= '0;
    end else if (load_i) begin
      mb_q    <= mb_sel;
      io_en_q <= desc_addr_i[DESC_W-1];
      step_q  <= {step_int_i, step_frac_i};
    end
  end

  dag_offset #(.OFS_W(OFS_W), .STEP_W(STEP_W)) u_ofs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .init_i (ofs_init),
    .adv_i  (fire),
    .step_i (step_q),
    .ofs_o  (ofs)
  );

  // base occupies only bits above the slice, so add reduces to concatenation
  assign phys = {mb_q, ofs[OFS_W-1:FRAC_W]};

  dag_route #(.PA_W(PA_W), .DATA_W(DATA_W)) u_route (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (fire),
    .phys_i       (phys),
    .io_en_i      (io_en_q),
    .wr_req_i     (wr_req_i),
    .wdata_i      (wdata_i),
    .transp_en_i  (transp_en_i),
    .transp_val_i (transp_val_i),
    .addr_o       (addr_o),
    .io_sel_o     (io_sel_o),
    .wr_en_o      (wr_en_o),
    .wdata_o      (wdata_o),
    .valid_o      (valid_o)
  );
endmodule

// File: rtl/dag_chk.sv
module dag_chk #(
  parameter int unsigned PA_W   = 28,
  parameter int unsigned STEP_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              step_i,
  input logic              wr_req_i,
  input logic              transp_en_i,
  input logic [DATA_W-1:0] transp_val_i,
  input logic [STEP_W-1:0] step_q,
  input logic [PA_W-1:0]   addr_o,
  input logic              io_sel_o,
  input logic              wr_en_o,
  input logic [DATA_W-1:0] wdata_o,
  input logic              valid_o
);
  AST_VALID_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(step_i && !load_i) |-> valid_o); // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(step_i && !load_i)); // R10
  AST_WE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> valid_o && $past(wr_req_i)); // R9
  AST_TRANSP_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !($past(transp_en_i) && wdata_o == $past(transp_val_i))); // R9
  AST_IO_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_sel_o |-> valid_o && addr_o[15:12] == 4'hD); // R8
  AST_ZERO_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o) && step_q == '0 |-> addr_o == $past(addr_o)); // R4
endmodule

bind dma_addr_gen dag_chk #(.PA_W(PA_W), .STEP_W(STEP_W), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .load_i       (load_i),
  .step_i       (step_i),
  .wr_req_i     (wr_req_i),
  .transp_en_i  (transp_en_i),
  .transp_val_i (transp_val_i),
  .step_q       (step_q),
  .addr_o       (addr_o),
  .io_sel_o     (io_sel_o),
  .wr_en_o      (wr_en_o),
  .wdata_o      (wdata_o),
  .valid_o      (valid_o)
);

// File: tb/tb_dma_addr_gen.sv
module tb_dma_addr_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0;
  logic [23:0] desc_addr_i = '0;
  logic [7:0]  mbyte_i = '0;
  logic        rev_i = 1'b0;
  logic [7:0]  step_int_i = '0;
  logic [7:0]  step_frac_i = '0;
  logic        step_i = 1'b0;
  logic        wr_req_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic        transp_en_i = 1'b0;
  logic [7:0]  transp_val_i = '0;
  logic [27:0] addr_o;
  logic        io_sel_o, wr_en_o, valid_o;
  logic [7:0]  wdata_o;

  int errors = 0;
  int checks = 0;

  // bench model
  int unsigned m_ofs;   // 28-bit fixed point
  int unsigned m_mb;
  int          m_step;
  bit          m_io;

  always #2.5 clk_i = ~clk_i;

  dma_addr_gen dut (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_load(input bit io, input bit [2:0] hi, input bit [19:0] ofs,
                         input bit [7:0] mb, input bit rev, input bit [15:0] st);
    @(negedge clk_i);
    load_i = 1'b1; desc_addr_i = {io, hi, ofs}; mbyte_i = mb; rev_i = rev;
    step_int_i = st[15:8]; step_frac_i = st[7:0];
    @(negedge clk_i);
    load_i = 1'b0;
    m_ofs  = {4'h0, ofs, 8'h00};
    m_mb   = rev ? ((mb + hi) & 8'hFF) : mb;
    m_step = int'($signed(st));
    m_io   = io;
  endtask

  task automatic do_step(input string req, input bit wr, input bit [7:0] wd);
    int unsigned ea;
    bit ei, ew;
    @(negedge clk_i);
    step_i = 1'b1; wr_req_i = wr; wdata_i = wd;
    @(negedge clk_i);
    step_i = 1'b0; wr_req_i = 1'b0;
    ea = (m_mb << 20) | (m_ofs >> 8);
    ei = m_io && (((ea >> 12) & 15) == 13);
    ew = wr && !(transp_en_i && wd == transp_val_i);
    chk("R10", "valid", valid_o, 1);
    chk(req, "addr", addr_o, ea);
    chk("R8", "io_sel", io_sel_o, ei);
    chk("R9", "wr_en", wr_en_o, ew);
    if (wr) chk("R9", "wdata", wdata_o, wd);
    m_ofs = (m_ofs + m_step) & 32'h0FFF_FFFF;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", "addr", addr_o, 0);
    chk("R1", "valid", valid_o, 0);
    chk("R1", "wr_en", wr_en_o, 0);
    chk("R1", "io_sel", io_sel_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "valid after release", valid_o, 0);
    chk("R1", "wdata after release", wdata_o, 0);

    // R2 R6 R7: base selection sweep
    for (int rv = 0; rv < 2; rv++)
      for (int hi = 0; hi < 8; hi++)
        for (int k = 0; k < 3; k++) begin
          do_load(1'b0, 3'(hi), 20'h12345, (k == 0) ? 8'h00 : (k == 1) ? 8'h7F : 8'hFE,
                  1'(rv), 16'h0100);
          do_step(rv ? "R7" : "R6", 1'b0, 8'h00);
          do_step("R2", 1'b0, 8'h00);
        end

    // R3: half-byte fractional step
    do_load(1'b0, 3'd0, 20'h00010, 8'h01, 1'b0, 16'h0080);
    for (int i = 0; i < 6; i++) do_step("R3", 1'b0, 8'h00);
    do_load(1'b0, 3'd0, 20'h00100, 8'h01, 1'b0, 16'h0340);
    for (int i = 0; i < 6; i++) do_step("R3", 1'b0, 8'h00);

    // R5: downward wrap, step -1.0
    do_load(1'b0, 3'd0, 20'h00002, 8'h03, 1'b0, 16'hFF00);
    for (int i = 0; i < 5; i++) do_step("R5", 1'b0, 8'h00);
    // R5: upward wrap
    do_load(1'b0, 3'd2, 20'hFFFFE, 8'hC0, 1'b1, 16'h0100);
    for (int i = 0; i < 4; i++) do_step("R5", 1'b0, 8'h00);

    // R4: zero step holds
    do_load(1'b0, 3'd0, 20'hABCDE, 8'h05, 1'b0, 16'h0000);
    for (int i = 0; i < 4; i++) do_step("R4", 1'b0, 8'h00);

    // R8: I/O window sweep
    for (int io = 0; io < 2; io++)
      for (int nb = 0; nb < 16; nb++) begin
        do_load(1'(io), 3'd0, {4'h2, 4'(nb), 12'h345}, 8'h00, 1'b0, 16'h0100);
        do_step("R8", 1'b0, 8'h00);
      end

    // R9: transparency sweep
    transp_en_i = 1'b1; transp_val_i = 8'h5A;
    do_load(1'b0, 3'd0, 20'h00400, 8'h00, 1'b0, 16'h0000);
    for (int d = 0; d < 256; d++) do_step("R9", 1'b1, 8'(d));
    do_step("R9", 1'b0, 8'h11);
    transp_en_i = 1'b0;
    do_step("R9", 1'b1, 8'h5A);

    // R10: load cancels a simultaneous strobe; idle gives no valid
    @(negedge clk_i);
    load_i = 1'b1; step_i = 1'b1; desc_addr_i = 24'h000020;
    @(negedge clk_i);
    load_i = 1'b0; step_i = 1'b0;
    chk("R10", "valid on load+step", valid_o, 0);
    @(negedge clk_i);
    chk("R10", "valid idle", valid_o, 0);
    chk("R10", "wr_en idle", wr_en_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule